// File: doc/BRIEF.md
# Flag-Gated Serial Port Engine

This block is a full-duplex asynchronous serial port with a small byte-wide register interface. Two addresses are decoded. The data address holds two separate buffers. A write to it loads the transmit shifter, and a read from it returns the most recently accepted received byte. The control/status address holds the receive enable, the multiprocessor check, the interrupt enable, two hardware-set completion flags and the captured stop bit. Bit timing comes from an external tick at sixteen times the bit rate.

Frames are ten bits long and carry eight data bits. The receiver hands every completed frame to a gate. The gate commits the byte only when the previous byte has been acknowledged and, when multiprocessor checking is on, the stop bit reads 1. A byte that arrives while the receive flag is still set is dropped, and the unread byte is kept. A single interrupt line combines both flags under one enable bit.

Top module: `serial_port_engine`

## Requirements
- R1: A frame on `txd_o` is one low start bit, eight data bits with the least-significant bit first, and one high stop bit. Each bit lasts 16 ticks. The line rests high when idle.
- R2: A write to address 0 while the transmitter is idle starts a frame. A write to address 0 while a frame is still in progress, up to the end of its stop bit, is ignored.
- R3: The transmit flag (control bit 0) becomes 1 in the cycle the stop bit starts on `txd_o`, which is one bit time before the frame ends.
- R4: Frames are received only while the receive-enable bit (control bit 3) is 1. A frame sent while it is 0 leaves the receive flag and the receive buffer unchanged.
- R5: The receiver starts on a high-to-low transition and re-checks the line at mid start bit. A low pulse shorter than half a bit returns the receiver to idle without receiving anything.
- R6: Each bit is decided by a 2-of-3 majority of the samples taken at ticks 7, 8 and 9 of the bit. A one-tick glitch at the centre of a bit does not change the received value.
- R7: At the end of a frame, the byte is committed if the receive flag (control bit 1) is 0 and either the multiprocessor-check bit (control bit 4) is 0 or the sampled stop bit is 1. A commit loads the receive buffer, copies the stop bit into control bit 2 and sets the receive flag.
- R8: When the commit condition fails, the receive buffer, control bit 2 and the receive flag all keep their values. On overrun the first byte is kept.
- R9: Both flags are set only by hardware. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. Reset clears every control field.
- R10: `irq_o` is 1 exactly when the interrupt-enable bit (control bit 5) is 1 and at least one of the two flags is 1.
- R11: A read of address 0 returns the last committed received byte and never the byte written for transmission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| addr_i | input | 1 | Register select: 0 data, 1 control/status |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Interrupt request |

## Verification
A transmit bit counter that is off by one moves the rise of the transmit flag away from the stop-bit edge, and a flag check one bit time before the frame ends catches it. A receive sample point that is wrong, or a missing vote, shows up as a wrong byte on the first glitched hand-made frame. A broken start check shows up as a spurious receive flag about one frame after the glitch. Errors in the gate's state (a receive flag cleared too early, or the stop bit not gated) replace the kept byte or change control bit 2 on the very next frame. The byte scoreboard reports this at the following read.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int CB_TXF = 0;
  localparam int CB_RXF = 1;
  localparam int CB_RB9 = 2;
  localparam int CB_REN = 3;
  localparam int CB_MPC = 4;
  localparam int CB_IEN = 5;

  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              stop_start_o,
  output logic              txd_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              bit_end, busy;

  assign busy    = state_q != TX_IDLE;
  assign bit_end = tick_i && cnt_q == CNT_W'(OVS - 1);
  assign stop_start_o = bit_end && state_q == TX_DATA && idx_q == IDX_W'(DATA_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
    end else if (state_q == TX_IDLE) begin
      if (load_i) begin
        state_q <= TX_START;
        cnt_q   <= '0;
        sh_q    <= data_i;
      end
    end else if (tick_i) begin
      if (bit_end) begin
        cnt_q <= '0;
        unique case (state_q)
          TX_START: begin
            state_q <= TX_DATA;
            idx_q   <= '0;
          end
          TX_DATA: begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_W'(DATA_W - 1)) state_q <= TX_STOP;
          end
          default: state_q <= TX_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      TX_START: txd_o = 1'b0;
      TX_DATA:  txd_o = sh_q[0];
      default:  txd_o = 1'b1;
    endcase
  end

  AST_TX_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy) |=> !txd_o); // R2
  AST_TX_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && busy && !bit_end) |=> $stable(sh_q)); // R2
endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int VOTE_AT = OVS / 2 + 1;  // last of the three centre samples

  rx_state_e         state_q;
  logic [1:0]        sync_q;
  logic              prev_q;
  logic [1:0]        samp_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              stop_q, done_q;
  logic              line, vote, vote_pt;

  assign line    = sync_q[1];
  assign vote    = vote3({samp_q, line});
  assign vote_pt = tick_i && cnt_q == CNT_W'(VOTE_AT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      prev_q  <= 1'b1;
      samp_q  <= 2'b11;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      stop_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      done_q <= 1'b0;
      if (tick_i) begin
        prev_q <= line;
        samp_q <= {samp_q[0], line};
      end
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else if (tick_i) begin
        if (state_q == RX_IDLE) begin
          if (prev_q && !line) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (vote_pt) begin
            unique case (state_q)
              RX_START: if (vote) state_q <= RX_IDLE;  // false start
              RX_DATA:  sh_q <= {vote, sh_q[DATA_W-1:1]};
              default: begin
                stop_q  <= vote;
                done_q  <= 1'b1;
                state_q <= RX_IDLE;
              end
            endcase
          end
          if (cnt_q == CNT_W'(OVS - 1)) begin
            cnt_q <= '0;
            if (state_q == RX_START) begin
              state_q <= RX_DATA;
              idx_q   <= '0;
            end else if (state_q == RX_DATA) begin
              idx_q <= idx_q + 1'b1;
              if (idx_q == IDX_W'(DATA_W - 1)) state_q <= RX_STOP;
            end
          end
        end
      end
    end
  end

  assign done_o = done_q;
  assign data_o = sh_q;
  assign stop_o = stop_q;

  AST_RX_DONE_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(en_i)); // R4
  AST_RX_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
endmodule

// File: rtl/serial_port_engine.sv
module serial_port_engine
  import sport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              irq_o
);
  logic              txf_q, rxf_q, rb9_q, ren_q, mpc_q, ien_q;
  logic [DATA_W-1:0] rbuf_q;
  logic              tx_load, tx_stop_start;
  logic              rx_done, rx_stop, commit;
  logic [DATA_W-1:0] rx_data;
  logic              ctl_wr;

  assign tx_load = wr_i && !addr_i;
  assign ctl_wr  = wr_i && addr_i;

  sport_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .load_i       (tx_load),
    .data_i       (wdata_i),
    .stop_start_o (tx_stop_start),
    .txd_o        (txd_o)
  );

  sport_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .en_i   (ren_q),
    .rxd_i  (rxd_i),
    .done_o (rx_done),
    .data_o (rx_data),
    .stop_o (rx_stop)
  );

  // Acceptance gate: previous byte acknowledged, stop bit good when checked
  assign commit = rx_done && !rxf_q && (!mpc_q || rx_stop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txf_q  <= 1'b0;
      rxf_q  <= 1'b0;
      rb9_q  <= 1'b0;
      ren_q  <= 1'b0;
      mpc_q  <= 1'b0;
      ien_q  <= 1'b0;
      rbuf_q <= '0;
    end else begin
      if (ctl_wr) begin
        txf_q <= txf_q & wdata_i[CB_TXF];
        rxf_q <= rxf_q & wdata_i[CB_RXF];
        ren_q <= wdata_i[CB_REN];
        mpc_q <= wdata_i[CB_MPC];
        ien_q <= wdata_i[CB_IEN];
      end
      if (tx_stop_start) txf_q <= 1'b1;
      if (commit) begin
        rbuf_q <= rx_data;
        rb9_q  <= rx_stop;
        rxf_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i) begin
      rdata_o[CB_TXF] = txf_q;
      rdata_o[CB_RXF] = rxf_q;
      rdata_o[CB_RB9] = rb9_q;
      rdata_o[CB_REN] = ren_q;
      rdata_o[CB_MPC] = mpc_q;
      rdata_o[CB_IEN] = ien_q;
    end else begin
      rdata_o = rbuf_q;
    end
  end

  assign irq_o = ien_q & (txf_q | rxf_q);

  AST_TXF_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txf_q) |-> txd_o); // R3
  AST_RXF_FROM_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rxf_q) |-> $past(rx_done)); // R7
  AST_RBUF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxf_q && $past(rxf_q)) |-> ($stable(rbuf_q) && $stable(rb9_q))); // R8
  AST_MPC_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && mpc_q && !rx_stop && !rxf_q) |=> !rxf_q); // R8
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ien_q); // R10
endmodule

// File: tb/serial_port_engine_tb_top.sv
module serial_port_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       addr = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       txd, irq, rxd;
  logic       loop = 1'b0;
  logic       drv = 1'b1;
  logic [1:0] div = '0;
  int         cyc = 0;
  int         n_run = 0;
  int         n_fail = 0;
  logic [7:0] cfg = '0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) begin
    cyc  <= cyc + 1;
    div  <= div + 1'b1;
    tick <= (div == 2'd3);
  end

  assign rxd = loop ? txd : drv;

  serial_port_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wreg(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  // keep_* = 1 leaves a flag alone, 0 clears it
  task automatic wctl(input logic keep_tx, input logic keep_rx);
    wreg(1'b1, cfg | {6'b0, keep_rx, keep_tx});
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input int glitch_pos);
    logic [9:0] bits;
    bits = {stop, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      drv = bits[k];
      if (k == glitch_pos) begin
        repeat (32) @(negedge clk);
        drv = ~bits[k];
        repeat (4) @(negedge clk);
        drv = bits[k];
        repeat (28) @(negedge clk);
      end else begin
        repeat (64) @(negedge clk);
      end
    end
    drv = 1'b1;
    repeat (128) @(negedge clk);
  endtask

  // Scoreboard monitor: wait for the receive flag, pop and compare
  task automatic check_rx(input string tag);
    logic [7:0] c, d;
    logic [8:0] e;
    int t;
    t = 0;
    rreg(1'b1, c);
    while (!c[1] && t < 2000) begin
      @(negedge clk);
      rreg(1'b1, c);
      t++;
    end
    chk({tag, " flag"}, c[1], 1);
    if (exp_q.size() == 0) begin
      chk({tag, " queue"}, 0, 1);
    end else begin
      e = exp_q.pop_front();
      rreg(1'b0, d);
      chk({tag, " data"}, d, e[7:0]);
      chk({tag, " ninth"}, c[2], e[8]);
    end
  endtask

  initial begin
    wait (cyc >= 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected <150000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n0, bad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rreg(1'b1, d);
    chk("R9 reset ctrl", d, 0);
    chk("R1 idle high", txd, 1);
    chk("R10 reset irq", irq, 0);

    cfg = 8'h08;
    wctl(1'b0, 1'b0);
    loop = 1'b1;

    // R1 R2 R3 R11: loopback frame, a second write mid-frame is ignored
    exp_q.push_back({1'b1, 8'hA5});
    wreg(1'b0, 8'hA5);
    while (txd) @(negedge clk);
    n0 = cyc;
    for (int k = 0; k < 10; k++) begin
      if (k == 9) begin
        wait_cyc(n0 + 576 - 8);
        rreg(1'b1, d);
        chk("R3 txf before stop", d[0], 0);
        wait_cyc(n0 + 576 + 8);
        rreg(1'b1, d);
        chk("R3 txf at stop", d[0], 1);
      end
      wait_cyc(n0 + 32 + 64 * k);
      chk($sformatf("R1 tx bit %0d", k), txd,
          (k == 0) ? 0 : (k == 9) ? 1 : int'((8'hA5 >> (k - 1)) & 1));
      if (k == 4) wreg(1'b0, 8'h00);
    end
    check_rx("R7 R11 loopback");
    wait_cyc(n0 + 644);
    bad = 0;
    repeat (200) begin
      @(negedge clk);
      if (!txd) bad++;
    end
    chk("R2 busy write ignored", bad, 0);

    // R10 interrupt gating
    chk("R10 irq disabled", irq, 0);
    cfg = 8'h28;
    wctl(1'b1, 1'b1);
    @(negedge clk);
    chk("R10 irq enabled", irq, 1);
    wctl(1'b0, 1'b1);
    rreg(1'b1, d);
    chk("R9 txf cleared", d[1:0], 2'b10);

    // R8 overrun: second byte dropped
    wreg(1'b0, 8'h3C);
    repeat (760) @(negedge clk);
    rreg(1'b0, d);
    chk("R8 overrun keeps first", d, 8'hA5);
    rreg(1'b1, d);
    chk("R8 ninth kept", d[2], 1);
    wctl(1'b1, 1'b0);
    rreg(1'b1, d);
    chk("R9 rxf cleared", d[1], 0);
    wctl(1'b1, 1'b1);
    rreg(1'b1, d);
    chk("R9 write one no set", d[1], 0);
    chk("R10 irq from txf", irq, 1);
    wctl(1'b0, 1'b0);
    @(negedge clk);
    chk("R10 irq flags clear", irq, 0);

    // Hand-made frames
    loop = 1'b0;
    cfg = 8'h18;
    wctl(1'b0, 1'b0);
    send_frame(8'h5A, 1'b0, -1);
    rreg(1'b1, d);
    chk("R8 mpc bad stop no flag", d[1], 0);
    rreg(1'b0, d);
    chk("R8 mpc bad stop buffer", d, 8'hA5);

    exp_q.push_back({1'b1, 8'h5A});
    send_frame(8'h5A, 1'b1, -1);
    check_rx("R7 mpc good stop");
    wctl(1'b0, 1'b0);

    cfg = 8'h08;
    wctl(1'b0, 1'b0);
    exp_q.push_back({1'b0, 8'hC3});
    send_frame(8'hC3, 1'b0, -1);
    check_rx("R7 no mpc stop low");
    wctl(1'b0, 1'b0);

    cfg = 8'h00;
    wctl(1'b0, 1'b0);
    send_frame(8'h11, 1'b1, -1);
    rreg(1'b1, d);
    chk("R4 disabled no flag", d[1], 0);
    rreg(1'b0, d);
    chk("R4 disabled buffer", d, 8'hC3);
    cfg = 8'h08;
    wctl(1'b0, 1'b0);

    // R5 short low pulse
    drv = 1'b0;
    repeat (12) @(negedge clk);
    drv = 1'b1;
    repeat (700) @(negedge clk);
    rreg(1'b1, d);
    chk("R5 glitch no flag", d[1], 0);
    exp_q.push_back({1'b1, 8'h96});
    send_frame(8'h96, 1'b1, -1);
    check_rx("R5 frame after glitch");
    wctl(1'b0, 1'b0);

    // R6 majority vote against a one-tick glitch
    exp_q.push_back({1'b1, 8'h69});
    send_frame(8'h69, 1'b1, 4);
    check_rx("R6 glitch data bit");
    wctl(1'b0, 1'b0);
    exp_q.push_back({1'b1, 8'hF0});
    send_frame(8'hF0, 1'b1, 9);
    check_rx("R6 glitch stop bit");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule